// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a clocked domain. A qualified supply-good flag stands in for the analog comparator. When the flag is low, or when the active-low manual request is low, reset is driven at once. Once both conditions have cleared, reset stays asserted for a fixed settling delay. If either condition returns during that delay, the delay starts over from the beginning.

A watchdog watches a kick input from the supervised processor. Each level change on that input is brought through a two-flop synchronizer and then counts as a kick, whichever direction the change goes. If the kicks stop for longer than the timeout, the block issues a reset of exactly the settling delay and restarts the watchdog. A strap input turns the watchdog off. Reset is provided in both polarities.

An asynchronous power-on input clears all state and asserts reset. All delays are parameters counted in clock cycles. The defaults correspond to 200 ms at 1 MHz. A short-delay option selects the 25 ms equivalent.

Top module: `reset_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `sys_rst` is 1 in the same cycle, with no clock edge needed.
- R2: When both hold conditions are clear (`supply_ok`=1 and `man_rst_n`=1) before clock edge 1, reset stays asserted through edge TD_CYC-1 and is deasserted after edge TD_CYC.
- R3: If `supply_ok` falls during the settling delay, reset is asserted at once, and the full TD_CYC delay restarts when the flag returns.
- R4: `man_rst_n`=0 asserts reset in the same cycle. After it is released, the full TD_CYC delay runs before reset deasserts.
- R5: A rising or a falling change on `wdog_in` counts as a kick. A change sampled at edge k clears the idle count, so that with no further change reset rises after edge k+2+TOUT_CYC.
- R6: With the watchdog enabled and no kick, reset rises after TOUT_CYC edges of released reset. It then lasts exactly TD_CYC cycles, and the watchdog restarts from zero.
- R7: `sys_rst_n` is always the complement of `sys_rst`.
- R8: While `wdog_off`=1, the watchdog never causes a reset, however long the kick input stays idle.
- R9: Changes on `wdog_in` while reset is asserted have no effect. The timeout is measured from the edge at which reset deasserts.
- R10: `por_n`=0 asserts reset asynchronously and clears all counters. After `por_n` is released with both hold conditions clear, reset deasserts after TD_CYC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Synchronous supply-good flag |
| man_rst_n | input | 1 | Manual reset request, active low |
| wdog_in | input | 1 | Watchdog kick input, asynchronous |
| wdog_off | input | 1 | Strap that disables the watchdog |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
Hold-driven assertion of reset is combinational, so the bench checks it 1 ns after it drives the input at the falling edge. Releases are due on the TD_CYC-th rising edge after the inputs clear, so the bench checks both after TD_CYC-1 edges and after TD_CYC edges. A kick reaches the idle counter three edges after it is driven, because of the two synchronizer flops and the history flop, and the timeout windows are sampled at exactly that offset. The random phase compares both outputs at every falling edge against a bench model built from these latencies.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // Cycle counts assuming a 1 MHz supervisor clock.
  localparam int unsigned TD_LONG_CYC   = 200_000;   // 200 ms settling delay
  localparam int unsigned TD_SHORT_CYC  = 25_000;    // 25 ms settling delay
  localparam int unsigned TOUT_DEF_CYC  = 1_600_000; // 1.6 s watchdog timeout
  localparam int unsigned SYNC_DEF      = 2;         // synchronizer depth

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic toggled
);
  // stage STAGES is the history flop used for change detection
  logic [STAGES:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= 1'b0;
    else        stg_q[0] <= d;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= 1'b0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign toggled = stg_q[STAGES-1] ^ stg_q[STAGES];
endmodule

// File: rtl/rsup_delay.sv
module rsup_delay #(
  parameter int unsigned TD_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned TW = rsup_pkg::cnt_width(TD_CYC);
  localparam logic [TW-1:0] TD_VAL = TW'(TD_CYC);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)               cnt_d = TD_VAL;
    else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TD_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R2: without a reload the delay counter falls by exactly one per cycle
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - TW'(1)));
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
  parameter int unsigned TOUT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic off,
  input  logic rst_active,
  output logic expire
);
  localparam int unsigned WW = rsup_pkg::cnt_width(TOUT_CYC - 1);
  localparam logic [WW-1:0] LAST = WW'(TOUT_CYC - 1);

  logic [WW-1:0] idle_q, idle_d;
  logic          clr;

  always_comb begin
    expire = !off && !rst_active && !kick && (idle_q == LAST);
    clr    = off || rst_active || kick || expire;
    idle_d = clr ? '0 : idle_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  // R8: the strap silences the watchdog
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !expire);
  // R9: while reset is asserted the idle count is parked at zero
  p_parked_in_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (idle_q == '0));
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter bit          SHORT_TD = 1'b0,
  parameter int unsigned TD_CYC   = SHORT_TD ? rsup_pkg::TD_SHORT_CYC : rsup_pkg::TD_LONG_CYC,
  parameter int unsigned TOUT_CYC = rsup_pkg::TOUT_DEF_CYC,
  parameter int unsigned SYNC_STG = rsup_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  input  logic wdog_in,
  input  logic wdog_off,
  output logic sys_rst_n,
  output logic sys_rst
);
  logic hold_req;
  logic dly_busy;
  logic kick;
  logic wd_expire;

  assign hold_req = !supply_ok || !man_rst_n;

  rsup_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .d       (wdog_in),
    .toggled (kick)
  );

  rsup_delay #(.TD_CYC(TD_CYC)) u_delay (
    .clk   (clk),
    .rst_n (por_n),
    .load  (hold_req || wd_expire),
    .busy  (dly_busy)
  );

  rsup_watchdog #(.TOUT_CYC(TOUT_CYC)) u_wdog (
    .clk        (clk),
    .rst_n      (por_n),
    .kick       (kick),
    .off        (wdog_off),
    .rst_active (sys_rst),
    .expire     (wd_expire)
  );

  assign sys_rst   = hold_req || dly_busy;
  assign sys_rst_n = !sys_rst;

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |-> sys_rst);
  p_restart_r3: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> dly_busy);
  p_manual_r4: assert property (@(posedge clk) disable iff (!por_n)
    !man_rst_n |-> sys_rst);
  p_wd_fire_r6: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> sys_rst);
  p_complement_r7: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_n != sys_rst);
  p_release_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> ($past(supply_ok) && $past(man_rst_n)));
endmodule

// File: tb/reset_supervisor_bench.sv
module reset_supervisor_bench;
  localparam int unsigned TD   = 12;
  localparam int unsigned TOUT = 20;

  logic clk = 1'b0;
  logic por_n, supply_ok, man_rst_n, wdog_in, wdog_off;
  logic sys_rst_n, sys_rst;
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  reset_supervisor #(.TD_CYC(TD), .TOUT_CYC(TOUT)) u_reset_supervisor (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .wdog_in(wdog_in), .wdog_off(wdog_off), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
  );

  // Reference model built from the requirement latencies
  int unsigned m_tcnt, m_wcnt;
  logic m_s1, m_s2, m_s3;
  always @(posedge clk) begin : model
    logic hold, rst, edg, expv;
    if (!por_n) begin
      m_tcnt = TD; m_wcnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      hold = !supply_ok || !man_rst_n;
      rst  = hold || (m_tcnt != 0);
      edg  = m_s2 ^ m_s3;
      expv = !wdog_off && !rst && !edg && (m_wcnt == TOUT - 1);
      if (hold || expv)      m_tcnt = TD;
      else if (m_tcnt != 0)  m_tcnt = m_tcnt - 1;
      if (wdog_off || rst || edg || expv) m_wcnt = 0;
      else                                m_wcnt = m_wcnt + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wdog_in;
    end
  end

  function automatic logic model_rst();
    return !supply_ok || !man_rst_n || (m_tcnt != 0);
  endfunction

  task automatic check(input string req, input logic exp);
    tests++;
    if (sys_rst !== exp) begin
      fails++;
      $display("FAIL %s: sys_rst=%b expected %b at %0t", req, sys_rst, exp, $time);
    end
    tests++;
    if (sys_rst_n !== ~exp) begin
      fails++;
      $display("FAIL R7: sys_rst_n=%b expected %b at %0t", sys_rst_n, ~exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    por_n = 0; supply_ok = 1; man_rst_n = 1; wdog_in = 0; wdog_off = 0;
    step(3);
    check("R10 reset state", 1'b1);

    // R10 / R2: power-on release timing
    por_n = 1;
    step(TD - 1); check("R10 held", 1'b1);
    step(1);      check("R2 release", 1'b0);

    // R6: timeout with no kick, then exact td pulse
    step(TOUT - 1); check("R6 before timeout", 1'b0);
    step(1);        check("R6 timeout", 1'b1);
    step(TD - 1);   check("R6 pulse length", 1'b1);
    step(1);        check("R6 pulse end", 1'b0);

    // R5: regular kicks on both edges keep reset off
    for (int i = 0; i < 12; i++) begin
      step(8); wdog_in = ~wdog_in;
      check("R5 kicked", 1'b0);
    end
    step(TOUT + 2); check("R5 last kick window", 1'b0);
    step(1);        check("R5 expiry after kick", 1'b1);
    step(TD);       check("R6 restart", 1'b0);

    // R8: strap disables the watchdog
    wdog_off = 1;
    step(TOUT + 3); check("R8 idle", 1'b0);
    step(2 * TOUT); check("R8 long idle", 1'b0);

    // R1 / R3: supply loss and restart of the delay
    supply_ok = 0; #1; check("R1 immediate", 1'b1);
    step(5);          check("R1 held", 1'b1);
    supply_ok = 1;
    step(5);          check("R3 counting", 1'b1);
    supply_ok = 0; #1; check("R3 drop mid-delay", 1'b1);
    step(2); supply_ok = 1;
    step(TD - 1); check("R3 full delay", 1'b1);
    step(1);      check("R3 release", 1'b0);

    // R4: manual reset
    man_rst_n = 0; #1; check("R4 immediate", 1'b1);
    step(4); man_rst_n = 1;
    step(TD - 1); check("R4 full delay", 1'b1);
    step(1);      check("R4 release", 1'b0);

    // R9: kicks during reset ignored, timeout counted from release
    man_rst_n = 0; wdog_off = 0;
    for (int i = 0; i < 6; i++) begin
      step(2); wdog_in = ~wdog_in;
    end
    step(5); man_rst_n = 1;
    step(TD - 1);   check("R9 held", 1'b1);
    step(1);        check("R9 release", 1'b0);
    step(TOUT - 1); check("R9 before timeout", 1'b0);
    step(1);        check("R9 timeout from release", 1'b1);
    step(TD);       check("R6 second pulse end", 1'b0);

    // Random phase against the bench model
    por_n = 0; step(2); por_n = 1;
    begin
      int rate = 15;
      for (int c = 0; c < 4000; c++) begin
        if (c % 500 == 0)  rate = (c % 1000 == 0) ? 15 : 3;
        if (c % 1300 == 650) wdog_off = ~wdog_off;
        if (supply_ok && ($urandom % 1000) < 4)        supply_ok = 0;
        else if (!supply_ok && ($urandom % 1000) < 300) supply_ok = 1;
        if (man_rst_n && ($urandom % 1000) < 3)        man_rst_n = 0;
        else if (!man_rst_n && ($urandom % 1000) < 250) man_rst_n = 1;
        if (($urandom % 100) < rate) wdog_in = ~wdog_in;
        #1;
        check("R1-model random", model_rst());
        step(1);
      end
    end
    summary();
  end
endmodule